// File: doc/BRIEF.md
# Compressed Table Jump Expander

This block sits between the compressed-instruction decoder and the rest of the decode path in a small 32-bit core with no address translation. Most instructions pass through it untouched. When the decoder marks a 16-bit instruction as a table jump, the block takes over.

First it forms the address of an entry in a jump table, using a table-base register and an index carried in the instruction. It then issues one word read on a memory request port and holds fetch stalled. When the read data comes back, it emits a real 32-bit JAL that reaches the fetched target from the current PC.

There are two forms. The non-linking form discards the return address. The linking form writes register x1. Because the emitted instruction is flagged as compressed, the later stages save PC plus 2 as the return address.

Top module: `tjx_expander`

## Requirements
- R1: While reset is asserted (active low, asynchronous) and on the first cycle after it, the block is idle. The stall and memory request outputs are low.
- R2: When the table-jump flag is low and the block is idle, the instruction, illegal and compressed outputs equal the matching inputs in the same cycle.
- R3: The stall output is high from the cycle in which a flagged instruction is presented to the block while idle. It stays high through every cycle up to, but not including, the emit cycle. It is low in the emit cycle.
- R4: The table index is instruction bits [9:2]. The entry address is the table base with its low 6 bits forced to zero, plus four times the index, taken modulo 2^32. Its bits [1:0] are always zero.
- R5: Exactly one read is issued per table jump. The request stays high with a stable address until the cycle in which the grant is seen.
- R6: An index below 32 selects the non-linking form, which gives rd = x0 (bits [11:7] = 0). An index of 32 or more selects the linking form, which gives rd = x1.
- R7: The emitted instruction is a JAL (opcode 7'b1101111). Its 21-bit offset is (read data with bit 0 cleared) minus the PC of the table jump, taken modulo 2^21. The offset bits are placed as inst[31]=off[20], inst[30:21]=off[10:1], inst[20]=off[11] and inst[19:12]=off[19:12].
- R8: The emit cycle lasts exactly one cycle. In it the compressed output is 1 and the illegal output is 0. The block is idle on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction from the compressed decoder |
| pc_i | input | 32 | PC of the instruction |
| tj_flag_i | input | 1 | Instruction is a table jump |
| illegal_i | input | 1 | Illegal flag from the decoder |
| compressed_i | input | 1 | Compressed flag from the decoder |
| tbl_base_i | input | 32 | Jump table base register |
| mem_req_o | output | 1 | Read request |
| mem_addr_o | output | 32 | Read word address |
| mem_gnt_i | input | 1 | Request accepted |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data (table entry) |
| instr_o | output | 32 | Instruction to decode |
| illegal_o | output | 1 | Illegal flag out |
| compressed_o | output | 1 | Compressed flag out |
| stall_o | output | 1 | Fetch stall |

## Verification
The assertions rely on a few things about the inputs. The front end holds the instruction, PC and base steady while stall is high. The memory never raises read-valid before it has granted the request, and answers each grant with one read-valid. The bench meets this with a responder that grants at random after the request appears. It then returns data one to three cycles later, and only in the waiting phase. The stimulus changes the instruction inputs only at falling edges after stall has dropped. Targets are drawn close to the PC, so the offset fits in 21 bits and is checked exactly.

// File: rtl/tjx_pkg.sv
package tjx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_EMIT  = 2'd3
  } tjx_state_e;

  localparam logic [6:0] OPC_JAL = 7'b1101111;

  // Entry address: aligned base plus scaled index.
  function automatic logic [31:0] tjx_entry_addr(input logic [31:0] base,
                                                 input logic [7:0]  idx,
                                                 input int unsigned align_bits);
    logic [31:0] mask;
    mask = ~((32'd1 << align_bits) - 32'd1);
    return (base & mask) + {22'd0, idx, 2'b00};
  endfunction

  // Build a JAL from a byte offset and a destination register.
  function automatic logic [31:0] tjx_jal(input logic [20:0] off,
                                          input logic [4:0]  rd);
    return {off[20], off[10:1], off[11], off[19:12], rd, OPC_JAL};
  endfunction

endpackage

// File: rtl/tjx_addr_gen.sv
module tjx_addr_gen #(
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned LINK_SPLIT = 32,
  parameter int unsigned ALIGN_BITS = 6
) (
  input  logic [31:0]      base_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [31:0]      addr_o,
  output logic             link_o
);
  import tjx_pkg::*;

  always_comb begin
    addr_o = tjx_entry_addr(base_i, idx_i, ALIGN_BITS);
    link_o = (32'(idx_i) >= LINK_SPLIT);
  end
endmodule

// File: rtl/tjx_jal_build.sv
module tjx_jal_build (
  input  logic [31:0] target_i,
  input  logic [31:0] pc_i,
  input  logic        link_i,
  output logic [31:0] instr_o
);
  import tjx_pkg::*;

  logic [31:0] diff;

  always_comb begin
    diff    = {target_i[31:1], 1'b0} - pc_i;
    instr_o = tjx_jal(diff[20:0], link_i ? 5'd1 : 5'd0);
  end
endmodule

// File: rtl/tjx_seq.sv
module tjx_seq (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [31:0] addr_i,
  input  logic        link_i,
  input  logic [31:0] pc_i,
  input  logic        gnt_i,
  input  logic        rvalid_i,
  input  logic [31:0] rdata_i,
  output tjx_pkg::tjx_state_e state_o,
  output logic        req_o,
  output logic [31:0] req_addr_o,
  output logic [31:0] target_o,
  output logic [31:0] pc_o,
  output logic        link_o
);
  import tjx_pkg::*;

  tjx_state_e state_q, state_d;
  logic [31:0] addr_q, target_q, pc_q;
  logic        link_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i)  state_d = ST_REQ;
      ST_REQ:  if (gnt_i)    state_d = ST_WAIT;
      ST_WAIT: if (rvalid_i) state_d = ST_EMIT;
      ST_EMIT:               state_d = ST_IDLE;
      default:               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      target_q <= '0;
      pc_q     <= '0;
      link_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start_i) begin
        addr_q <= addr_i;
        pc_q   <= pc_i;
        link_q <= link_i;
      end
      if (state_q == ST_WAIT && rvalid_i) target_q <= rdata_i;
    end
  end

  assign state_o    = state_q;
  assign req_o      = (state_q == ST_REQ);
  assign req_addr_o = addr_q;
  assign target_o   = target_q;
  assign pc_o       = pc_q;
  assign link_o     = link_q;
endmodule

// File: rtl/tjx_expander.sv
module tjx_expander #(
  parameter int unsigned IDX_LSB    = 2,
  parameter int unsigned IDX_W      = 8,
  parameter int unsigned LINK_SPLIT = 32,
  parameter int unsigned ALIGN_BITS = 6
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] instr_i,
  input  logic [31:0] pc_i,
  input  logic        tj_flag_i,
  input  logic        illegal_i,
  input  logic        compressed_i,
  input  logic [31:0] tbl_base_i,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic [31:0] instr_o,
  output logic        illegal_o,
  output logic        compressed_o,
  output logic        stall_o
);
  import tjx_pkg::*;

  localparam int unsigned IDX_MSB = IDX_LSB + IDX_W - 1;

  logic [31:0] entry_addr, lat_target, lat_pc, jal_word;
  logic        entry_link, lat_link;
  tjx_state_e  state;

  // Named events for the checker.
  logic idle_w, busy_w, emit_w, start_w;

  tjx_addr_gen #(.IDX_W(IDX_W), .LINK_SPLIT(LINK_SPLIT), .ALIGN_BITS(ALIGN_BITS)) u_addr (
    .base_i (tbl_base_i),
    .idx_i  (instr_i[IDX_MSB:IDX_LSB]),
    .addr_o (entry_addr),
    .link_o (entry_link)
  );

  tjx_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (tj_flag_i),
    .addr_i     (entry_addr),
    .link_i     (entry_link),
    .pc_i       (pc_i),
    .gnt_i      (mem_gnt_i),
    .rvalid_i   (mem_rvalid_i),
    .rdata_i    (mem_rdata_i),
    .state_o    (state),
    .req_o      (mem_req_o),
    .req_addr_o (mem_addr_o),
    .target_o   (lat_target),
    .pc_o       (lat_pc),
    .link_o     (lat_link)
  );

  tjx_jal_build u_jal (
    .target_i (lat_target),
    .pc_i     (lat_pc),
    .link_i   (lat_link),
    .instr_o  (jal_word)
  );

  assign idle_w  = (state == ST_IDLE);
  assign emit_w  = (state == ST_EMIT);
  assign busy_w  = (state == ST_REQ) || (state == ST_WAIT);
  assign start_w = idle_w && tj_flag_i;

  always_comb begin
    stall_o = start_w || busy_w;
    if (emit_w) begin
      instr_o      = jal_word;
      illegal_o    = 1'b0;
      compressed_o = 1'b1;
    end else begin
      instr_o      = instr_i;
      illegal_o    = illegal_i;
      compressed_o = compressed_i;
    end
  end
endmodule

// File: rtl/tjx_checker.sv
module tjx_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic        mem_gnt_i,
  input logic [31:0] mem_addr_o,
  input logic        stall_o,
  input logic        compressed_o,
  input logic        illegal_o,
  input logic        emit_w,
  input logic        busy_w,
  input logic        start_w
);
  // R5: an ungranted request is held with the same address
  a_r5_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));

  // R3: a request outstanding means fetch is stalled
  a_r3_stall_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> stall_o);

  // R3: starting a table jump leads into the busy phase
  a_r3_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_w |=> busy_w && stall_o);

  // R4: word-aligned table reads
  a_r4_word_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  // R8: emit is a single unstalled compressed cycle
  a_r8_emit_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_w |-> compressed_o && !illegal_o && !stall_o);

  a_r8_emit_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    emit_w |=> !emit_w && !busy_w);

  // R5: a granted request drops the next cycle
  a_r5_one_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_gnt_i |=> !mem_req_o);
endmodule

bind tjx_expander tjx_checker u_tjx_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mem_req_o    (mem_req_o),
  .mem_gnt_i    (mem_gnt_i),
  .mem_addr_o   (mem_addr_o),
  .stall_o      (stall_o),
  .compressed_o (compressed_o),
  .illegal_o    (illegal_o),
  .emit_w       (emit_w),
  .busy_w       (busy_w),
  .start_w      (start_w)
);

// File: tb/tb_tjx_expander.sv
module tb_tjx_expander;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] instr_i = '0, pc_i = '0, tbl_base_i = '0, mem_rdata_i = '0;
  logic        tj_flag_i = 1'b0, illegal_i = 1'b0, compressed_i = 1'b0;
  logic        mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0;
  logic        mem_req_o, illegal_o, compressed_o, stall_o;
  logic [31:0] mem_addr_o, instr_o;

  int n_checks = 0, n_fail = 0;
  int pend = 0, n_grants = 0;
  logic [31:0] got_addr = '0, cur_target = '0;
  logic        resp_en = 1'b0;

  always #2.5 clk_i = ~clk_i;

  tjx_expander dut (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory responder: random grant, data 1..3 cycles later.
  always @(negedge clk_i) begin
    mem_gnt_i    = 1'b0;
    mem_rvalid_i = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = cur_target;
      end
    end else if (resp_en && mem_req_o && ($urandom % 2 == 0)) begin
      mem_gnt_i = 1'b1;
      got_addr  = mem_addr_o;
      n_grants++;
      pend = 1 + ($urandom % 3);
    end
  end

  function automatic logic [31:0] exp_addr(input logic [31:0] base, input logic [7:0] idx);
    return {base[31:6], 6'd0} + 32'(idx) * 4;
  endfunction

  function automatic logic [31:0] exp_jal(input logic [31:0] tgt, input logic [31:0] pc, input logic [7:0] idx);
    logic [31:0] d, w;
    d = (tgt & 32'hFFFF_FFFE) - pc;
    w = 32'h0000_006F;
    if (idx >= 8'd32) w[7] = 1'b1;
    for (int b = 1; b <= 10; b++) w[20 + b] = d[b];
    w[20] = d[11];
    for (int b = 12; b <= 19; b++) w[b] = d[b];
    w[31] = d[20];
    return w;
  endfunction

  task automatic pass_through(input logic [31:0] ins, input bit ill, input bit cmp);
    @(negedge clk_i);
    tj_flag_i = 1'b0; instr_i = ins; illegal_i = ill; compressed_i = cmp;
    #0.5;
    check(instr_o == ins && illegal_o == ill && compressed_o == cmp, "R2 passthrough",
          {instr_o[31:2], illegal_o, compressed_o}, {ins[31:2], ill, cmp});
    check(!stall_o && !mem_req_o, "R2 no stall", {30'd0, stall_o, mem_req_o}, 32'd0);
  endtask

  task automatic table_jump(input logic [7:0] idx, input logic [31:0] pc,
                            input logic [31:0] base, input logic [31:0] tgt);
    int cyc = 0;
    bit stall_ok = 1'b1;
    int g0;
    @(negedge clk_i);
    g0 = n_grants;
    cur_target = tgt;
    instr_i = {16'h0, 3'b101, 3'b000, idx, 2'b10};
    pc_i = pc; tbl_base_i = base; tj_flag_i = 1'b1;
    illegal_i = 1'b1; compressed_i = 1'b1;
    #0.5;
    check(stall_o == 1'b1, "R3 stall on start", {31'd0, stall_o}, 32'd1);
    resp_en = 1'b1;
    forever begin
      @(negedge clk_i);
      #0.5;
      cyc++;
      if (!stall_o || cyc > 40) break;
    end
    resp_en = 1'b0;
    if (cyc > 40) stall_ok = 1'b0;
    check(stall_ok, "R3 stall ends at emit", 32'(cyc), 32'd40);
    check(got_addr == exp_addr(base, idx), "R4 entry address", got_addr, exp_addr(base, idx));
    check(n_grants - g0 == 1, "R5 single read", 32'(n_grants - g0), 32'd1);
    check(instr_o == exp_jal(tgt, pc, idx), "R7 jal word", instr_o, exp_jal(tgt, pc, idx));
    check(instr_o[11:7] == ((idx >= 8'd32) ? 5'd1 : 5'd0), "R6 rd select",
          32'(instr_o[11:7]), (idx >= 8'd32) ? 32'd1 : 32'd0);
    check(compressed_o && !illegal_o, "R8 emit flags", {30'd0, compressed_o, illegal_o}, 32'd2);
    #0.5;
    tj_flag_i = 1'b0;
    @(negedge clk_i);
    #0.5;
    check(!stall_o && instr_o == instr_i, "R8 idle after emit", instr_o, instr_i);
  endtask

  initial begin
    #300000;
    n_checks++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #1;
    check(!stall_o && !mem_req_o, "R1 in reset", {30'd0, stall_o, mem_req_o}, 32'd0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!stall_o && !mem_req_o, "R1 after reset", {30'd0, stall_o, mem_req_o}, 32'd0);
    // Directed corners
    pass_through(32'hDEAD_BEEF, 1'b1, 1'b0);
    pass_through(32'h0000_4501, 1'b0, 1'b1);
    table_jump(8'd0,   32'h0000_1000, 32'h0002_0000, 32'h0000_2000);
    table_jump(8'd31,  32'h0000_1002, 32'h0002_003F, 32'h0000_0F00);
    table_jump(8'd32,  32'h8000_0010, 32'hFFFF_FFC5, 32'h800F_FFF1);
    table_jump(8'd255, 32'h8010_0000, 32'hFFFF_FFFF, 32'h8000_0000);
    // Random mix
    for (int k = 0; k < 60; k++) begin
      logic [31:0] p, off;
      p   = $urandom & 32'hFFFF_FFFE;
      off = 32'($urandom % 32'h0010_0000) - 32'h0008_0000;
      if ($urandom % 3 == 0)
        pass_through($urandom, 1'($urandom), 1'($urandom));
      else
        table_jump(8'($urandom), p, $urandom, p + off);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule